// File: doc/BRIEF.md
# Trigger Input Conditioner Bank

This block sits between the synchronized trigger inputs of a data acquisition trigger crate and the logic that classifies events. It holds one conditioner per trigger lane. The default lane count covers all input groups: thirty backplane lanes, thirty front-panel lanes and fifteen more front-panel lanes. In each lane, a rising edge of the single-bit input counts as one trigger. Software can switch each lane on or off and can set a divide-by-P prescale for it. The lane emits a one-cycle conditioned pulse for every trigger it passes.

Every lane also keeps two saturating monitoring counters. The raw counter counts every input edge, before the enable and before the prescale. The passed counter counts only the pulses the lane emits. A single clear strobe zeroes every counter in the bank. A registered read port returns one counter of one lane. Configuration is written one lane at a time. The logic runs on the system pipeline clock (250 MHz in the target system).

Top module: `trig_cond_bank`

## Requirements
- R1: After reset, every lane is disabled with prescale 0, trig_out is all zero, and every counter reads 0.
- R2: A rising edge of trig_in[i] is one trigger: the raw counter of lane i advances by exactly one, however long the input stays high. If that trigger is passed, trig_out[i] is high for exactly the one cycle after the clock edge that samples the rising input.
- R3: While lane i is disabled, trig_out[i] stays low and the lane's passed counter does not change. Its raw counter still counts edges.
- R4: With prescale value P of 2 or more, an enabled lane passes every P-th enabled trigger, counted from reset or from the last configuration write to that lane. A value of 0 or 1 passes every enabled trigger.
- R5: A configuration write (cfg_we with cfg_lane = i) loads the enable and prescale of lane i only and restarts its prescale count. A trigger in the cycle of that write is counted raw but is neither passed nor counted toward the prescale.
- R6: Both counters of a lane stop at their all-ones maximum (2^CNTW - 1) and do not wrap.
- R7: scaler_clr zeroes every counter of every lane on the next clock edge. An edge in the same cycle as the clear is not counted. The clear does not change the enables, the prescales or trig_out.
- R8: rd_data shows, one clock after the request, the counter of lane rd_lane selected by rd_sel (0 = raw, 1 = passed). A lane number of NLANE or above reads 0.
- R9: Lanes are independent: the inputs and configuration of one lane never change the outputs or counters of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NLANE | Synchronized trigger inputs, one per lane |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lane | input | LW | Lane addressed by the configuration write |
| cfg_enable | input | 1 | Enable value to load |
| cfg_prescale | input | PSW | Prescale value to load |
| scaler_clr | input | 1 | Clear strobe for all counters |
| rd_lane | input | LW | Lane whose counter is read |
| rd_sel | input | 1 | Counter select: 0 raw, 1 passed |
| rd_data | output | CNTW | Registered counter read data |
| trig_out | output | NLANE | Conditioned trigger pulses, one per lane |

## Verification
Directed sequences exercise the basic behaviours. A long pulse must give one count, not one per cycle, which separates edge detection from level counting. A disabled lane is driven with pulses to show that raw and passed counting are split. Divide-by-three and divide-by-zero runs separate the prescale count from a pass-all lane. A reconfiguration is written partway through a count, and a clear is applied together with an edge, to pin down which event wins. A long toggle train runs the narrow bench counters into saturation. A constrained-random phase then mixes edges on all lanes with scattered writes, clears and reads, and compares every cycle against a model of all the lanes. Any leak between lanes or any wrong read-port mux shows up there.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

  typedef enum logic {
    SEL_RAW  = 1'b0,
    SEL_PASS = 1'b1
  } cnt_sel_e;

  // True when the trigger now being qualified completes a prescale period.
  function automatic logic ps_last(input logic [31:0] cnt, input logic [31:0] ps);
    return (ps < 32'd2) || (cnt == ps - 32'd1);
  endfunction

  // Saturating increment on a 32-bit container; max is the all-ones limit.
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] max);
    return (v == max) ? v : v + 32'd1;
  endfunction

endpackage

// File: rtl/trig_scaler.sv
module trig_scaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  import trig_cond_pkg::*;

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [31:0]  next_w;

  always_comb next_w = sat_step(32'(cnt_q), 32'(MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= next_w[W-1:0];
  end

  assign cnt_o = cnt_q;

  p_saturate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr) |=> (cnt_q == MAXV));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + W'(1)));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));

endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
  parameter int PSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_en,
  input  logic [PSW-1:0] cfg_ps,
  input  logic           edge_i,
  output logic           hit_o,
  output logic           pass_o
);
  import trig_cond_pkg::*;

  logic           en_q;
  logic [PSW-1:0] ps_q;
  logic [PSW-1:0] cnt_q;
  logic           pass_q;
  logic           qualify_w;
  logic           last_w;

  // A write in the same cycle wins over a trigger for the prescale path.
  assign qualify_w = edge_i && en_q && !cfg_we;
  assign last_w    = ps_last(32'(cnt_q), 32'(ps_q));
  assign hit_o     = qualify_w && last_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ps_q   <= '0;
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      pass_q <= hit_o;
      if (cfg_we) begin
        en_q  <= cfg_en;
        ps_q  <= cfg_ps;
        cnt_q <= '0;
      end else if (qualify_w) begin
        cnt_q <= last_w ? '0 : cnt_q + PSW'(1);
      end
    end
  end

  assign pass_o = pass_q;

  p_pass_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> $past(edge_i && en_q));

  p_cnt_below_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_q >= PSW'(2)) |-> (cnt_q < ps_q));

  p_cfg_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt_q == '0 && !pass_q));

  p_pass_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |=> !pass_q);

endmodule

// File: rtl/trig_lane.sv
module trig_lane #(
  parameter int PSW  = 16,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic            cfg_we,
  input  logic            cfg_en,
  input  logic [PSW-1:0]  cfg_ps,
  input  logic            clr,
  output logic            trig_o,
  output logic [CNTW-1:0] raw_cnt,
  output logic [CNTW-1:0] pass_cnt
);
  logic prev_q;
  logic edge_w;
  logic hit_w;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= trig_i;
  end

  assign edge_w = trig_i && !prev_q;

  trig_prescaler #(.PSW(PSW)) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .cfg_en (cfg_en),
    .cfg_ps (cfg_ps),
    .edge_i (edge_w),
    .hit_o  (hit_w),
    .pass_o (trig_o)
  );

  trig_scaler #(.W(CNTW)) u_raw (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (edge_w),
    .cnt_o (raw_cnt)
  );

  trig_scaler #(.W(CNTW)) u_pass (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (hit_w),
    .cnt_o (pass_cnt)
  );

  p_out_has_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(edge_w));

  p_pass_le_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pass_cnt <= raw_cnt));

endmodule

// File: rtl/trig_read_mux.sv
module trig_read_mux #(
  parameter int NLANE = 75,
  parameter int CNTW  = 32,
  parameter int LW    = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NLANE-1:0][CNTW-1:0]  raw_cnt,
  input  logic [NLANE-1:0][CNTW-1:0]  pass_cnt,
  input  logic [LW-1:0]               rd_lane,
  input  trig_cond_pkg::cnt_sel_e     rd_sel,
  output logic [CNTW-1:0]             rd_data
);
  import trig_cond_pkg::*;

  logic [CNTW-1:0] mux_w;
  logic [CNTW-1:0] data_q;

  always_comb begin
    mux_w = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (rd_lane == LW'(i)) mux_w = (rd_sel == SEL_PASS) ? pass_cnt[i] : raw_cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= mux_w;
  end

  assign rd_data = data_q;

  p_oor_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lane >= LW'(NLANE)) |=> (data_q == '0));

endmodule

// File: rtl/trig_cond_bank.sv
module trig_cond_bank #(
  parameter int NLANE = 75,
  parameter int PSW   = 16,
  parameter int CNTW  = 32,
  parameter int LW    = $clog2(NLANE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLANE-1:0] trig_in,
  input  logic             cfg_we,
  input  logic [LW-1:0]    cfg_lane,
  input  logic             cfg_enable,
  input  logic [PSW-1:0]   cfg_prescale,
  input  logic             scaler_clr,
  input  logic [LW-1:0]    rd_lane,
  input  logic             rd_sel,
  output logic [CNTW-1:0]  rd_data,
  output logic [NLANE-1:0] trig_out
);
  import trig_cond_pkg::*;

  logic [NLANE-1:0][CNTW-1:0] raw_cnt;
  logic [NLANE-1:0][CNTW-1:0] pass_cnt;
  logic [NLANE-1:0]           lane_we;
  cnt_sel_e                   sel_w;

  assign sel_w = cnt_sel_e'(rd_sel);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_we[g] = cfg_we && (cfg_lane == LW'(g));

    trig_lane #(.PSW(PSW), .CNTW(CNTW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_i   (trig_in[g]),
      .cfg_we   (lane_we[g]),
      .cfg_en   (cfg_enable),
      .cfg_ps   (cfg_prescale),
      .clr      (scaler_clr),
      .trig_o   (trig_out[g]),
      .raw_cnt  (raw_cnt[g]),
      .pass_cnt (pass_cnt[g])
    );
  end

  trig_read_mux #(.NLANE(NLANE), .CNTW(CNTW), .LW(LW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_cnt  (raw_cnt),
    .pass_cnt (pass_cnt),
    .rd_lane  (rd_lane),
    .rd_sel   (sel_w),
    .rd_data  (rd_data)
  );

  p_one_lane_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

  p_out_needs_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_out & ~$past(trig_in)) == '0));

endmodule

// File: tb/trig_cond_bank_bench.sv
module trig_cond_bank_bench;
  localparam int NL   = 6;
  localparam int PSW  = 4;
  localparam int CW   = 10;
  localparam int LW   = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] trig_in = '0;
  logic          cfg_we = 1'b0;
  logic [LW-1:0] cfg_lane = '0;
  logic          cfg_enable = 1'b0;
  logic [PSW-1:0] cfg_prescale = '0;
  logic          scaler_clr = 1'b0;
  logic [LW-1:0] rd_lane = '0;
  logic          rd_sel = 1'b0;
  logic [CW-1:0] rd_data;
  logic [NL-1:0] trig_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_raw [NL];
  int m_pass[NL];
  int m_ps  [NL];
  int m_cnt [NL];
  bit m_en  [NL];
  bit m_prev[NL];
  logic [NL-1:0] cur_t = '0;

  always #5 clk = ~clk;

  trig_cond_bank #(.NLANE(NL), .PSW(PSW), .CNTW(CW)) u_trig_cond_bank (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_we(cfg_we),
    .cfg_lane(cfg_lane), .cfg_enable(cfg_enable), .cfg_prescale(cfg_prescale),
    .scaler_clr(scaler_clr), .rd_lane(rd_lane), .rd_sel(rd_sel),
    .rd_data(rd_data), .trig_out(trig_out)
  );

  function automatic int bump(input int v);
    if (v >= MAXC) return MAXC;
    return v + 1;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // One clock: drive at negedge, update model, check trig_out at next negedge.
  task automatic tick(input logic [NL-1:0] t, input bit we, input int lane,
                      input bit en, input int ps, input bit clr, input string tag);
    logic [NL-1:0] exp_out;
    exp_out = '0;
    trig_in      = t;
    cfg_we       = we;
    cfg_lane     = LW'(lane);
    cfg_enable   = en;
    cfg_prescale = PSW'(ps);
    scaler_clr   = clr;
    for (int i = 0; i < NL; i++) begin
      bit e, wr, hit;
      e = t[i] && !m_prev[i];
      m_prev[i] = t[i];
      wr = we && (lane == i);
      hit = 0;
      if (e && m_en[i] && !wr) begin
        int c;
        c = m_cnt[i] + 1;
        if (m_ps[i] <= 1 || c == m_ps[i]) begin hit = 1; m_cnt[i] = 0; end
        else m_cnt[i] = c;
      end
      if (clr) begin m_raw[i] = 0; m_pass[i] = 0; end
      else begin
        if (e) m_raw[i] = bump(m_raw[i]);
        if (hit) m_pass[i] = bump(m_pass[i]);
      end
      if (wr) begin m_en[i] = en; m_ps[i] = ps; m_cnt[i] = 0; end
      exp_out[i] = hit;
    end
    cur_t = t;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    scaler_clr = 1'b0;
    chk({tag, " trig_out"}, int'(trig_out), int'(exp_out));
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(cur_t, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input int lane, input bit en, input int ps);
    tick(cur_t, 1, lane, en, ps, 0, "R5 cfg");
  endtask

  task automatic pulse(input int lane, input int hi, input string tag);
    logic [NL-1:0] v;
    v = cur_t | (NL'(1) << lane);
    for (int k = 0; k < hi; k++) tick(v, 0, 0, 0, 0, 0, tag);
    v = cur_t & ~(NL'(1) << lane);
    tick(v, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int lane, input bit sel, input string tag);
    int exp;
    rd_lane = LW'(lane);
    rd_sel  = sel;
    tick(cur_t, 0, 0, 0, 0, 0, tag);
    if (lane >= NL) exp = 0;
    else exp = sel ? m_pass[lane] : m_raw[lane];
    chk({tag, sel ? " passed" : " raw"}, int'(rd_data), exp);
  endtask

  task automatic rd_all(input string tag);
    for (int l = 0; l < NL; l++) begin
      rd(l, 0, tag);
      rd(l, 1, tag);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_raw[i] = 0; m_pass[i] = 0; m_ps[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_prev[i] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 trig_out after reset", int'(trig_out), 0);
    rd_all("R1 reset");
    // R1: disabled after reset, so pulses do not pass
    pulse(0, 1, "R1 disabled at reset");

    // R2: long pulse counted once, pass-all lane
    cfg(0, 1, 1);
    pulse(0, 6, "R2 long pulse");
    pulse(0, 1, "R2 short pulse");
    rd(0, 0, "R2 lane0");
    rd(0, 1, "R2 lane0");

    // R3: disabled lane counts raw only
    for (int k = 0; k < 4; k++) pulse(1, 2, "R3 disabled");
    rd(1, 0, "R3 lane1");
    rd(1, 1, "R3 lane1");

    // R4: divide by three and divide by zero
    cfg(2, 1, 3);
    cfg(3, 1, 0);
    for (int k = 0; k < 7; k++) begin
      pulse(2, 1, "R4 div3");
      pulse(3, 1, "R4 div0");
    end
    rd(2, 1, "R4 lane2");
    rd(3, 1, "R4 lane3");

    // R5: restart mid-count, edge in the write cycle
    pulse(2, 1, "R5 pre");
    tick(cur_t | 6'b000100, 1, 2, 1, 3, 0, "R5 write with edge");
    tick(cur_t & ~6'b000100, 0, 0, 0, 0, 0, "R5");
    for (int k = 0; k < 3; k++) pulse(2, 1, "R5 post");
    rd(2, 0, "R5 lane2");
    rd(2, 1, "R5 lane2");

    // R7: clear with a simultaneous edge
    tick(cur_t | 6'b000001, 0, 0, 0, 0, 1, "R7 clear with edge");
    tick(cur_t & ~6'b000001, 0, 0, 0, 0, 0, "R7");
    rd_all("R7 after clear");
    pulse(0, 1, "R7 still enabled");
    rd(0, 1, "R7 lane0");

    // R6: saturation of both counters of lane 4
    cfg(4, 1, 1);
    for (int k = 0; k < MAXC + 20; k++) pulse(4, 1, "R6 toggle");
    rd(4, 0, "R6 lane4");
    rd(4, 1, "R6 lane4");

    // R8: out-of-range lanes read zero
    rd(6, 0, "R8 oor");
    rd(7, 1, "R8 oor");

    // R9: random mix across lanes
    for (int n = 0; n < 3000; n++) begin
      logic [NL-1:0] t;
      int r;
      t = NL'($urandom);
      r = int'($urandom_range(0, 199));
      if (r < 5)       tick(t, 1, int'($urandom_range(0, NL - 1)), bit'($urandom_range(0, 1)),
                            int'($urandom_range(0, 15)), 0, "R9 random cfg");
      else if (r == 5) tick(t, 0, 0, 0, 0, 1, "R9 random clear");
      else             tick(t, 0, 0, 0, 0, 0, "R9 random");
      if (r > 190) rd(int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), "R9 random read");
    end
    idle(2, "R9");
    rd_all("R9 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule